// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Decoder

This block judges the integrity of one or two 256-byte flash data sections. For each section it takes two check words: the one read back from the spare area and the one the datapath has just computed over the data. Each check word carries 22 meaningful bits in a 24-bit slot. These are two 11-bit fields: a parity field in bits 10:0 and a complementary parity field in bits 21:11. The block XORs the two words into a syndrome and classifies the result. For a single flipped data bit it also reports the byte offset and the bit position to repair. Applying that repair to memory is left to the caller.

A strobe launches one decode. Every result appears one clock later, together with a one-cycle result-valid pulse, and stays on the outputs until the next strobe. In wide mode a second section is decoded from the next 24-bit code slot. A single failure flag then reports whether either section failed.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: `res_valid_o` is high exactly in the cycle after a cycle with `chk_valid_i` high. All other result outputs change only in that cycle and otherwise hold their last values.
- R2: When the 22 used bits of the computed and stored words are equal, the section status is 2'b00 (clean).
- R3: When either the computed word or the stored word has all 22 used bits zero, the section status is 2'b00, whatever the syndrome.
- R4: A syndrome with exactly one bit set gives status 2'b01 (check field damaged), and the section counts as failed.
- R5: A syndrome with exactly 11 bits set is a correctable error when its low field XOR its high field equals 0x7FF. In that case the status is 2'b10, the bit position is syndrome bits 2:0 and the byte offset is syndrome bits 10:3, and the section does not count as failed.
- R6: Every other nonzero syndrome gives status 2'b11 (uncorrectable), and the section counts as failed.
- R7: The byte and bit outputs of a section are zero unless that section's status is 2'b10.
- R8: With `wide_i` high, section 1 decodes bits 45:24 of both code inputs and `fail_o` is the OR of both section failures. With `wide_i` low, section 1 reports status 2'b00 with zero byte and bit, and it cannot raise `fail_o`.
- R9: Code bits 23:22 and 47:46 have no effect on any output.
- R10: While reset is asserted, `res_valid_o`, all statuses, the byte and bit outputs and `fail_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid_i | input | 1 | Start one decode with the codes present this cycle |
| wide_i | input | 1 | Decode two sections (512-byte mode) |
| calc_code_i | input | 48 | Computed check words; section k in bits 24k+23:24k |
| stored_code_i | input | 48 | Stored check words; same slot layout |
| res_valid_o | output | 1 | One-cycle pulse marking new results |
| sec_status_o | output | 4 | Status per section, 2 bits each, section 0 in bits 1:0 |
| err_byte_o | output | 16 | Failing byte offset per section, 8 bits each |
| err_bit_o | output | 6 | Failing bit position per section, 3 bits each |
| fail_o | output | 1 | Any enabled section damaged or uncorrectable |

## Verification
Assertions check the following on every cycle. Equal codes or an all-zero code word in section 0 always yield a clean status. A single-bit syndrome always yields the check-field status. Byte and bit stay zero outside a correction. Narrow mode never shows a section-1 result. The bench scenarios cover what needs chosen stimulus. These are exact correction coordinates at both ends of the range and 11-bit syndromes that fail the pair test. They also cover mixed outcomes across the two sections of a wide decode, the hold of results between strobes, and the indifference to pad bits.

// File: rtl/ecc_dec_pkg.sv
package ecc_dec_pkg;
  localparam int FIELD_W  = 11;
  localparam int CODE_W   = 2 * FIELD_W;
  localparam int SLOT_W   = ((CODE_W + 7) / 8) * 8;
  localparam int BIT_W    = 3;
  localparam int BYTE_W   = FIELD_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIELD   = 2'b01,
    ST_FIXABLE = 2'b10,
    ST_FATAL   = 2'b11
  } sec_status_e;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int N = 22,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int LEAVES = 1 << LEVELS;

  logic [CW-1:0] node [0:LEVELS][0:LEAVES-1];

  // leaves: one input bit each, padding zero
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[0][i] = CW'(bits_i[i]);
    end else begin : g_pad
      assign node[0][i] = '0;
    end
  end

  // balanced pairwise adder tree
  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < LEAVES; i++) begin : g_node
      if (i < (LEAVES >> l)) begin : g_add
        assign node[l][i] = node[l-1][2*i] + node[l-1][2*i+1];
      end else begin : g_idle
        assign node[l][i] = '0;
      end
    end
  end

  assign count_o = node[LEVELS][0];
endmodule

// File: rtl/ecc_section_classify.sv
module ecc_section_classify
  import ecc_dec_pkg::*;
#(
  parameter int FW = FIELD_W,
  localparam int CWD = 2 * FW,
  localparam int BW  = BIT_W,
  localparam int YW  = FW - BIT_W,
  localparam int PCW = $clog2(CWD + 1)
) (
  input  logic [CWD-1:0] calc_i,
  input  logic [CWD-1:0] stored_i,
  output sec_status_e    status_o,
  output logic [YW-1:0]  byte_o,
  output logic [BW-1:0]  bit_o
);
  logic [CWD-1:0] syndrome;
  logic [FW-1:0]  syn_lo;
  logic [FW-1:0]  pair_chk;
  logic [PCW-1:0] syn_weight;
  logic           any_zero_word;

  assign syndrome = calc_i ^ stored_i;
  assign syn_lo   = calc_i[FW-1:0] ^ stored_i[FW-1:0];
  assign pair_chk = (calc_i[FW-1:0] ^ calc_i[CWD-1:FW]) ^
                    (stored_i[FW-1:0] ^ stored_i[CWD-1:FW]);
  assign any_zero_word = (calc_i == '0) || (stored_i == '0);

  ecc_popcount #(.N(CWD)) u_weight (
    .bits_i  (syndrome),
    .count_o (syn_weight)
  );

  always_comb begin
    status_o = ST_FATAL;
    byte_o   = '0;
    bit_o    = '0;
    if ((syndrome == '0) || any_zero_word) begin
      status_o = ST_CLEAN;
    end else if (syn_weight == PCW'(1)) begin
      status_o = ST_FIELD;
    end else if ((syn_weight == PCW'(FW)) && (pair_chk == {FW{1'b1}})) begin
      status_o = ST_FIXABLE;
      bit_o    = syn_lo[BW-1:0];
      byte_o   = syn_lo[FW-1:BW];
    end
  end
endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
  import ecc_dec_pkg::*;
#(
  parameter int SECTIONS = 2,
  localparam int TOT_W = SECTIONS * SLOT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_valid_i,
  input  logic                     wide_i,
  input  logic [TOT_W-1:0]         calc_code_i,
  input  logic [TOT_W-1:0]         stored_code_i,
  output logic                     res_valid_o,
  output logic [2*SECTIONS-1:0]    sec_status_o,
  output logic [BYTE_W*SECTIONS-1:0] err_byte_o,
  output logic [BIT_W*SECTIONS-1:0]  err_bit_o,
  output logic                     fail_o
);
  sec_status_e cls_status [SECTIONS];
  logic [BYTE_W-1:0] cls_byte [SECTIONS];
  logic [BIT_W-1:0]  cls_bit  [SECTIONS];
  logic [SECTIONS-1:0] sec_en;
  logic [2*(SLOT_W-CODE_W)*SECTIONS-1:0] unused_pad;

  for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
    ecc_section_classify #(.FW(FIELD_W)) u_cls (
      .calc_i   (calc_code_i[k*SLOT_W +: CODE_W]),
      .stored_i (stored_code_i[k*SLOT_W +: CODE_W]),
      .status_o (cls_status[k]),
      .byte_o   (cls_byte[k]),
      .bit_o    (cls_bit[k])
    );
    if (k == 0) begin : g_always
      assign sec_en[k] = 1'b1;
    end else begin : g_wide
      assign sec_en[k] = wide_i;
    end
    assign unused_pad[k*2*(SLOT_W-CODE_W) +: 2*(SLOT_W-CODE_W)] =
      {calc_code_i[k*SLOT_W+CODE_W +: SLOT_W-CODE_W],
       stored_code_i[k*SLOT_W+CODE_W +: SLOT_W-CODE_W]};
  end

  // next-state
  logic                        valid_q;
  logic [2*SECTIONS-1:0]       status_q, status_n;
  logic [BYTE_W*SECTIONS-1:0]  byte_q, byte_n;
  logic [BIT_W*SECTIONS-1:0]   bit_q, bit_n;
  logic                        fail_q, fail_n;

  always_comb begin
    status_n = '0;
    byte_n   = '0;
    bit_n    = '0;
    fail_n   = 1'b0;
    for (int k = 0; k < SECTIONS; k++) begin
      if (sec_en[k]) begin
        status_n[2*k +: 2]          = cls_status[k];
        byte_n[BYTE_W*k +: BYTE_W]  = cls_byte[k];
        bit_n[BIT_W*k +: BIT_W]     = cls_bit[k];
        if ((cls_status[k] == ST_FIELD) || (cls_status[k] == ST_FATAL))
          fail_n = 1'b1;
      end
    end
  end

  // registers, loaded under the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      status_q <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
      fail_q   <= 1'b0;
    end else begin
      valid_q <= chk_valid_i;
      if (chk_valid_i) begin
        status_q <= status_n;
        byte_q   <= byte_n;
        bit_q    <= bit_n;
        fail_q   <= fail_n;
      end
    end
  end

  assign res_valid_o  = valid_q;
  assign sec_status_o = status_q;
  assign err_byte_o   = byte_q;
  assign err_bit_o    = bit_q;
  assign fail_o       = fail_q;

  AST_EQUAL_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && (calc_code_i[CODE_W-1:0] == stored_code_i[CODE_W-1:0]))
    |=> (sec_status_o[1:0] == ST_CLEAN)) else $error("equal codes"); // R2

  AST_ZERO_WORD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && ((calc_code_i[CODE_W-1:0] == '0) || (stored_code_i[CODE_W-1:0] == '0)))
    |=> (sec_status_o[1:0] == ST_CLEAN)) else $error("zero word"); // R3

  AST_ONE_BIT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && (calc_code_i[CODE_W-1:0] != '0) && (stored_code_i[CODE_W-1:0] != '0) &&
     ($countones(calc_code_i[CODE_W-1:0] ^ stored_code_i[CODE_W-1:0]) == 1))
    |=> ((sec_status_o[1:0] == ST_FIELD) && fail_o)) else $error("single syndrome bit"); // R4

  AST_COORD_ONLY_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_status_o[1:0] != ST_FIXABLE) |-> ((err_byte_o[BYTE_W-1:0] == '0) && (err_bit_o[BIT_W-1:0] == '0)))
    else $error("coords outside fix"); // R7

  AST_NARROW_SEC1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && !wide_i) |=> (sec_status_o[2*SECTIONS-1:2] == '0))
    else $error("narrow mode upper section"); // R8

  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> (!res_valid_o && $stable(sec_status_o) && $stable(fail_o)))
    else $error("result moved without strobe"); // R1
endmodule

// File: tb/ecc_syndrome_decoder_bench.sv
module ecc_syndrome_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid_i;
  logic        wide_i;
  logic [47:0] calc_code_i;
  logic [47:0] stored_code_i;
  logic        res_valid_o;
  logic [3:0]  sec_status_o;
  logic [15:0] err_byte_o;
  logic [5:0]  err_bit_o;
  logic        fail_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected state of the model
  logic        e_valid;
  logic [3:0]  e_status;
  logic [15:0] e_byte;
  logic [5:0]  e_bit;
  logic        e_fail;

  always #5 clk = ~clk;

  ecc_syndrome_decoder u_ecc_syndrome_decoder (
    .clk (clk), .rst_n (rst_n), .chk_valid_i (chk_valid_i), .wide_i (wide_i),
    .calc_code_i (calc_code_i), .stored_code_i (stored_code_i),
    .res_valid_o (res_valid_o), .sec_status_o (sec_status_o),
    .err_byte_o (err_byte_o), .err_bit_o (err_bit_o), .fail_o (fail_o)
  );

  // behavioural reference for one section: {status, byte, bit}
  function automatic logic [12:0] ref_sec(input logic [21:0] c, input logic [21:0] s);
    logic [21:0] syn;
    logic [10:0] pr;
    int n;
    syn = c ^ s;
    n = 0;
    for (int i = 0; i < 22; i++) if (syn[i]) n++;
    pr = syn[10:0] ^ syn[21:11];
    if (syn == 0 || c == 0 || s == 0) return {2'b00, 11'd0};
    if (n == 1) return {2'b01, 11'd0};
    if (n == 11 && pr == 11'h7FF) return {2'b10, syn[10:3], syn[2:0]};
    return {2'b11, 11'd0};
  endfunction

  task automatic model_update();
    logic [12:0] r0, r1;
    e_valid = chk_valid_i;
    if (chk_valid_i) begin
      r0 = ref_sec(calc_code_i[21:0], stored_code_i[21:0]);
      r1 = wide_i ? ref_sec(calc_code_i[45:24], stored_code_i[45:24]) : 13'd0;
      e_status = {r1[12:11], r0[12:11]};
      e_byte   = {r1[10:3], r0[10:3]};
      e_bit    = {r1[2:0], r0[2:0]};
      e_fail   = (r0[12:11] == 2'b01) || (r0[12:11] == 2'b11) ||
                 (r1[12:11] == 2'b01) || (r1[12:11] == 2'b11);
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (res_valid_o !== e_valid || sec_status_o !== e_status || err_byte_o !== e_byte ||
        err_bit_o !== e_bit || fail_o !== e_fail) begin
      errors++;
      $display("FAIL %s: got v=%0b st=%h byte=%h bit=%h fail=%0b exp v=%0b st=%h byte=%h bit=%h fail=%0b",
               tag, res_valid_o, sec_status_o, err_byte_o, err_bit_o, fail_o,
               e_valid, e_status, e_byte, e_bit, e_fail);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [47:0] c,
                      input logic [47:0] s, input string tag);
    chk_valid_i   = v;
    wide_i        = w;
    calc_code_i   = c;
    stored_code_i = s;
    @(posedge clk);
    #1;
    model_update();
    compare(tag);
  endtask

  function automatic logic [21:0] flip_for(input logic [21:0] c, input logic [10:0] a);
    return c ^ {~a, a};
  endfunction

  initial begin
    logic [21:0] c0, c1;
    rst_n = 1'b0; chk_valid_i = 1'b0; wide_i = 1'b0;
    calc_code_i = '0; stored_code_i = '0;
    e_valid = 0; e_status = 0; e_byte = 0; e_bit = 0; e_fail = 0;
    @(posedge clk); #1;
    compare("R10 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    c0 = 22'h2B3C1D;
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, c0}, "R2 equal codes");
    step(1, 0, {24'd0, 24'd0}, {24'd0, 2'b00, 22'h155555}, "R3 computed zero");
    step(1, 0, {24'd0, 2'b00, 22'h3FFFFF}, {24'd0, 24'd0}, "R3 stored zero");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, c0 ^ 22'h000010}, "R4 low field bit");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, c0 ^ 22'h200000}, "R4 high field bit R7");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, flip_for(c0, 11'h000)}, "R5 byte0 bit0");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, flip_for(c0, 11'h7FF)}, "R5 byte255 bit7");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, flip_for(c0, 11'h2A5)}, "R5 mid offset");
    step(0, 1, {24'hFFFFFF, 24'h123456}, {24'h0, 24'h654321}, "R1 hold without strobe");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, c0 ^ 22'h000003}, "R6 two bits R7");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, c0 ^ {11'h001, 11'h3FF}}, "R6 eleven bits non-pair");
    step(1, 0, {24'd0, 2'b00, c0}, {24'd0, 2'b00, ~c0}, "R6 all bits");
    step(1, 0, {24'd0, 2'b11, c0}, {24'd0, 2'b00, c0}, "R9 pad bits differ");
    step(1, 1, {2'b10, c0, 2'b01, c0}, {2'b00, c0, 2'b00, c0}, "R9 pad bits wide");
    c1 = 22'h0F0F33;
    step(1, 1, {2'b00, c1, 2'b00, c0}, {2'b00, c1 ^ 22'h000081, 2'b00, flip_for(c0, 11'h0C4)},
         "R8 fix plus fatal");
    step(1, 1, {2'b00, c1, 2'b00, c0}, {2'b00, c1 ^ 22'h000400, 2'b00, c0}, "R8 clean plus field");
    step(1, 1, {2'b00, c1, 2'b00, c0}, {2'b00, flip_for(c1, 11'h1F3), 2'b00, flip_for(c0, 11'h011)},
         "R8 both fixable");
    step(1, 0, {2'b00, c1, 2'b00, c0}, {2'b00, c1 ^ 22'h000081, 2'b00, c0}, "R8 narrow ignores upper");
    step(0, 0, '0, '0, "R1 result pulse ends");

    for (int i = 0; i < 300; i++) begin
      logic [21:0] a, b, x, y;
      logic [2:0] kind;
      a = 22'($urandom); x = 22'($urandom);
      kind = 3'($urandom);
      case (kind)
        3'd0: b = a;
        3'd1: b = a ^ (22'd1 << ($urandom % 22));
        3'd2, 3'd3: b = flip_for(a, 11'($urandom));
        default: b = 22'($urandom);
      endcase
      y = (kind[0]) ? flip_for(x, 11'($urandom)) : 22'($urandom);
      step(1'($urandom), 1'($urandom), {2'($urandom), x, 2'($urandom), a},
           {2'($urandom), y, 2'($urandom), b}, "R5 R6 R8 random");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got no completion exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule